// File: doc/BRIEF.md
# Contrast PWM Generator

This block produces one pulse-width-modulated output intended to set display contrast or backlight brightness. Software programs two registers through a small register port: a control word that picks a clock prescale, an output sense and an enable, and an 8-bit duty value. The system clock is slowed by the chosen prescale and advances an 8-bit period counter. The output is active while the counter is below the duty value that is in force for the current period.

A duty value written by software is held in a shadow until the period counter wraps, so each period is formed from one duty value only and no shortened pulse appears. While the enable bit is clear the output sits at its inactive level: low for positive sense, high for inverted sense. A duty of zero with positive sense therefore gives a steady low output with the enable set, identical to the disabled level, so that switching the backlight off by writing zero causes no edge.

Top module: `contrast_pwm`

## Requirements
- R1: After reset the duty register reads 0xC8, the control register reads 0x00 and the output is low.
- R2: Address 0 selects the control register and address 1 the duty register; a write is visible on the read data from the next clock cycle, and the read data is the selected register zero-extended.
- R3: Control field positions: bits 1:0 prescale select, bit 2 invert (1 = inverted sense), bit 3 enable; bits above bit 3 are not stored and read as 0.
- R4: Prescale select 0, 1, 2, 3 advance the period counter once every 1, 2, 4, 8 clocks, so one output period lasts 256, 512, 1024, 2048 clocks.
- R5: With positive sense and the enable set, the output is high for duty x divide clocks of every period.
- R6: With inverted sense and the enable set, the output is the complement of the positive-sense waveform, low for duty x divide clocks of every period.
- R7: With the enable clear the output is constant: low with positive sense, high with inverted sense.
- R8: A duty value written while enabled does not change the waveform until the period counter wraps from 255 to 0.
- R9: A duty of 0 with positive sense keeps the output low for every cycle while enabled; a duty of 0xFF gives 255 high counts out of every 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 duty |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pwm_out | output | 1 | PWM output after sense and enable |

## Verification
The hardest situation to reach from the ports is a duty change in the middle of an active period, because the period counter and the shadow duty are not visible. The stimulus enables the block from the disabled state, which puts the counter at a known zero, waits 20 clocks with a duty of 0x80, then writes a much smaller duty; the output must stay high for the following 80 clocks, and a full-period window taken after the wrap must show the new high count. All other waveform checks count high cycles over a window exactly one period long, which makes the expected count independent of the counter phase.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   // Prescale select width and the control field layout
   localparam int PSEL_W  = 2;
   localparam int PSEL_LO = 0;
   localparam int INV_BIT = 2;
   localparam int EN_BIT  = 3;
   localparam int CTRL_W  = 4;

   typedef enum logic {
      ADDR_CTRL = 1'b0,
      ADDR_DUTY = 1'b1
   } cpwm_addr_e;

   typedef struct packed {
      logic              en;
      logic              inv;
      logic [PSEL_W-1:0] psel;
   } cpwm_ctrl_t;

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
   import cpwm_pkg::*;
#(
   parameter int               DUTY_W   = 8,
   parameter logic [DUTY_W-1:0] DUTY_RST = 8'hC8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              addr,
   input  logic [DUTY_W-1:0] wdata,
   output logic [DUTY_W-1:0] rdata,
   output cpwm_ctrl_t        ctrl,
   output logic [DUTY_W-1:0] duty
);

   generate
      if (DUTY_W < CTRL_W) begin : g_bad_width
         $error("cpwm_regs: DUTY_W must hold the control word");
      end
   endgenerate

   cpwm_ctrl_t        ctrl_q;
   logic [DUTY_W-1:0] duty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         duty_q <= DUTY_RST;
      end else if (we) begin
         if (addr == ADDR_CTRL) ctrl_q <= cpwm_ctrl_t'(wdata[CTRL_W-1:0]);
         else                   duty_q <= wdata;
      end
   end

   always_comb begin
      if (addr == ADDR_CTRL) rdata = {{(DUTY_W-CTRL_W){1'b0}}, ctrl_q};
      else                   rdata = duty_q;
   end

   assign ctrl = ctrl_q;
   assign duty = duty_q;

   AST_WR_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we && addr == ADDR_DUTY) |-> duty_q == $past(wdata)); // R2

endmodule

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler
   import cpwm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PSEL_W-1:0] psel,
   output logic              tick
);

   localparam int NSEL  = 1 << PSEL_W;
   localparam int DIV_W = NSEL - 1;

   logic [DIV_W-1:0] div_cnt;
   logic [NSEL-1:0]  cand;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_cnt <= '0;
      else        div_cnt <= div_cnt + 1'b1;
   end

   generate
      for (genvar s = 0; s < NSEL; s++) begin : g_sel
         if (s == 0) begin : g_div1
            assign cand[s] = 1'b1;
         end else begin : g_divn
            assign cand[s] = &div_cnt[s-1:0];
         end
      end
   endgenerate

   assign tick = cand[psel];

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && psel != '0 && $stable(psel)) |-> !tick); // R4

endmodule

// File: rtl/cpwm_core.sv
module cpwm_core #(
   parameter int DUTY_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              inv,
   input  logic              tick,
   input  logic [DUTY_W-1:0] duty_reg,
   output logic              pwm_out
);

   logic [DUTY_W-1:0] cnt;
   logic [DUTY_W-1:0] duty_act;
   logic              wrap;
   logic              raw;
   logic              pwm_q;

   assign wrap = tick && (cnt == {DUTY_W{1'b1}});
   assign raw  = cnt < duty_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         duty_act <= '0;
      end else if (!en) begin
         cnt      <= '0;
         duty_act <= duty_reg;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
         if (wrap) duty_act <= duty_reg;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pwm_q <= 1'b0;
      else if (en)  pwm_q <= raw ^ inv;
      else          pwm_q <= inv;
   end

   assign pwm_out = pwm_q;

   AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !$past(wrap)) |-> $stable(duty_act)); // R8

   AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !inv && duty_act == '0) |=> !pwm_q); // R9

   AST_DIS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!en) && $past(!en, 2) && $past(inv) == $past(inv, 2)) |-> $stable(pwm_q)); // R7

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && $past(tick)) |-> cnt == DUTY_W'($past(cnt) + 1'b1)); // R4

endmodule

// File: rtl/contrast_pwm.sv
module contrast_pwm
   import cpwm_pkg::*;
#(
   parameter int               DUTY_W   = 8,
   parameter logic [DUTY_W-1:0] DUTY_RST = 8'hC8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_addr,
   input  logic [DUTY_W-1:0] reg_wdata,
   output logic [DUTY_W-1:0] reg_rdata,
   output logic              pwm_out
);

   cpwm_ctrl_t        ctrl;
   logic [DUTY_W-1:0] duty;
   logic              tick;

   cpwm_regs #(.DUTY_W(DUTY_W), .DUTY_RST(DUTY_RST)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .ctrl  (ctrl),
      .duty  (duty)
   );

   cpwm_prescaler u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .psel  (ctrl.psel),
      .tick  (tick)
   );

   cpwm_core #(.DUTY_W(DUTY_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl.en),
      .inv      (ctrl.inv),
      .tick     (tick),
      .duty_reg (duty),
      .pwm_out  (pwm_out)
   );

endmodule

// File: tb/sim_contrast_pwm.sv
module sim_contrast_pwm;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       pwm_out;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   contrast_pwm u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pwm_out   (pwm_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic a, output int d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic count_high(input int n, output int h);
      h = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out) h++;
      end
   endtask

   task automatic t_reset();
      int d;
      rd(1'b1, d); chk("R1 duty reset", d, 8'hC8);
      rd(1'b0, d); chk("R1 ctrl reset", d, 0);
      chk("R1 output reset", pwm_out, 0);
   endtask

   task automatic t_regs();
      int d;
      wr(1'b1, 8'h5A);
      rd(1'b1, d); chk("R2 duty readback", d, 8'h5A);
      wr(1'b0, 8'hF2);
      rd(1'b0, d); chk("R3 ctrl upper bits dropped", d, 8'h02);
      wr(1'b0, 8'h00);
   endtask

   task automatic t_rate(input int sel, input int duty);
      int h;
      int per;
      per = 256 << sel;
      wr(1'b0, 8'h00);
      wr(1'b1, 8'(duty));
      wr(1'b0, 8'(8'h08 | sel));
      repeat (per + 10) @(negedge clk);
      count_high(per, h);
      chk($sformatf("R4 R5 sel=%0d high count", sel), h, duty << sel);
   endtask

   task automatic t_invert();
      int h;
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h30);
      wr(1'b0, 8'h0C);
      repeat (270) @(negedge clk);
      count_high(256, h);
      chk("R6 inverted high count", h, 256 - 8'h30);
   endtask

   task automatic t_disabled();
      int h;
      wr(1'b0, 8'h00);
      repeat (3) @(negedge clk);
      count_high(50, h);
      chk("R7 disabled positive held low", h, 0);
      wr(1'b0, 8'h04);
      repeat (3) @(negedge clk);
      count_high(50, h);
      chk("R7 disabled inverted held high", h, 50);
   endtask

   task automatic t_deferred();
      int h;
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h80);
      wr(1'b0, 8'h08);
      repeat (20) @(negedge clk);
      wr(1'b1, 8'h04);
      count_high(80, h);
      chk("R8 old duty kept until wrap", h, 80);
      repeat (200) @(negedge clk);
      count_high(256, h);
      chk("R8 new duty after wrap", h, 4);
   endtask

   task automatic t_extremes();
      int h;
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h08);
      count_high(600, h);
      chk("R9 zero duty stays low", h, 0);
      wr(1'b0, 8'h00);
      wr(1'b1, 8'hFF);
      wr(1'b0, 8'h08);
      repeat (270) @(negedge clk);
      count_high(256, h);
      chk("R9 full duty high count", h, 255);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_rate(0, 8'h40);
      t_rate(1, 8'h30);
      t_rate(2, 8'h11);
      t_rate(3, 8'h20);
      t_invert();
      t_disabled();
      t_deferred();
      t_extremes();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule